// File: doc/BRIEF.md
# Lockable SMM Memory-Window Controller

This block holds one small configuration register and routes processor memory requests. A fixed legacy window in low memory can be mapped to DRAM or sent to an alternate target, which is a graphics device or a downstream broadcast. The choice depends on a two-bit window mode, on whether the request is made in system-management mode (SMM), and on whether it is a code fetch. Requests outside the window always go to DRAM. For every valid request the block raises exactly one one-cycle strobe, either to DRAM or to the alternate target, on the clock after the request.

Firmware sets up the window and then sets a one-way lock bit. After that, ordinary software can no longer move the protected region or unlock it. While locked, only the low mode bit stays writable, and only if the high mode bit is 1. This lets a protected window be opened and closed between SMM entries.

A second region lies in extended memory and is bounded by base and limit inputs. The block watches it: a request from outside SMM that hits this region sets a sticky violation flag. Explicit-writeback traffic never sets the flag. Software clears the flag by writing 1 to it.

Top module: `smm_window_ctrl`

## Requirements
- R1: The register reads back combinationally on `cfg_rdata`, with these fields: bits [1:0] are the window mode, bit 2 is the range enable, bit 3 is the lock, bits [5:4] are the size field, and bit 6 is the violation flag. After reset all bits are 0 and neither strobe is high.
- R2: While unlocked, a write loads bits [5:0] from `cfg_wdata`. Bit 6 of the write data only clears the flag (R10).
- R3: A request is in the window when `WIN_BASE <= req_addr < WIN_BASE+WIN_SIZE`. A request outside the window is routed to DRAM in every mode.
- R4: In mode 00 every window request goes to the alternate target. In mode 01 every window request goes to DRAM.
- R5: In mode 10 only a window request with `req_smm=1` and `req_code=1` goes to DRAM. Every other window request goes to the alternate target.
- R6: In mode 11 a window request goes to DRAM exactly when `req_smm=1`, whatever the value of `req_code`.
- R7: A valid request in cycle t produces exactly one of `route_dram` or `route_alt`, high only in cycle t+1. With no request, both stay low.
- R8: Once the lock bit is 1, only reset clears it. While locked, writes leave the lock bit, mode bit 1, the range enable and the size field unchanged.
- R9: While locked, mode bit 0 takes the written value if mode bit 1 is 1, and keeps its value otherwise.
- R10: The violation flag is set when a valid request has `req_smm=0` and `req_ewb=0`, the range enable is 1, and `ext_base <= req_addr < ext_limit`. It stays set until a write with bit 6 = 1. A write with bit 6 = 0 leaves it unchanged.
- R11: A request with `req_ewb=1`, or any request while the range enable is 0, never sets the violation flag.
- R12: When a set and a write-1-to-clear happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 7 | Register write data |
| cfg_rdata | output | 7 | Register read data |
| ext_base | input | ADDR_W | Lower bound of the extended protected range (inclusive) |
| ext_limit | input | ADDR_W | Upper bound of the extended protected range (exclusive) |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_smm | input | 1 | Request made in SMM |
| req_code | input | 1 | Request is a code fetch |
| req_ewb | input | 1 | Request is an explicit writeback |
| route_dram | output | 1 | One-cycle strobe: request served by DRAM |
| route_alt | output | 1 | One-cycle strobe: request sent to the alternate target |

## Verification
The assertions assume that `ext_base` and `ext_limit` stay constant while requests are issued and that `ext_base` is not above `ext_limit`. The bench sets the two bounds once, before any traffic, and never changes them. The assertions also assume that routing reads the mode that is registered in the cycle of the request. For this reason the bench never issues a request in the same cycle as a mode write. The only overlap of a write and a request is the deliberate set-versus-clear collision, and that write keeps the mode unchanged.

// File: rtl/smm_window_ctrl.sv
module smm_window_ctrl #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h0002_0000,
  localparam int EN_BIT   = 2,
  localparam int LOCK_BIT = 3,
  localparam int SZ_LO    = 4,
  localparam int VIOL_BIT = SZ_LO + SIZE_W,
  localparam int CFG_W    = VIOL_BIT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [ADDR_W-1:0] ext_base,
  input  logic [ADDR_W-1:0] ext_limit,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_smm,
  input  logic              req_code,
  input  logic              req_ewb,
  output logic              route_dram,
  output logic              route_alt
);

  logic [1:0]        mode;
  logic              rng_en;
  logic              locked;
  logic [SIZE_W-1:0] size_f;
  logic              viol;

  logic in_win, ext_hit, go_dram, viol_set, viol_clr;

  assign in_win  = (req_addr >= WIN_BASE) && ((req_addr - WIN_BASE) < WIN_SIZE);
  assign ext_hit = rng_en && (req_addr >= ext_base) && (req_addr < ext_limit);

  always_comb begin
    go_dram = 1'b1;
    if (in_win) begin
      unique case (mode)
        2'b00: go_dram = 1'b0;
        2'b01: go_dram = 1'b1;
        2'b10: go_dram = req_smm && req_code;
        2'b11: go_dram = req_smm;
        default: go_dram = 1'b1;
      endcase
    end
  end

  assign viol_set = req_valid && ext_hit && !req_smm && !req_ewb;
  assign viol_clr = cfg_we && cfg_wdata[VIOL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= '0;
      rng_en     <= 1'b0;
      locked     <= 1'b0;
      size_f     <= '0;
      viol       <= 1'b0;
      route_dram <= 1'b0;
      route_alt  <= 1'b0;
    end else begin
      if (cfg_we) begin
        if (!locked) begin
          mode   <= cfg_wdata[1:0];
          rng_en <= cfg_wdata[EN_BIT];
          locked <= cfg_wdata[LOCK_BIT];
          size_f <= cfg_wdata[SZ_LO +: SIZE_W];
        end else if (mode[1]) begin
          mode[0] <= cfg_wdata[0];
        end
      end
      viol       <= viol_set || (viol && !viol_clr);
      route_dram <= req_valid && go_dram;
      route_alt  <= req_valid && !go_dram;
    end
  end

  assign cfg_rdata = {viol, size_f, locked, rng_en, mode};

endmodule

// File: rtl/smm_window_chk.sv
module smm_window_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h0002_0000,
  localparam int SZ_LO    = 4,
  localparam int VIOL_BIT = SZ_LO + SIZE_W,
  localparam int CFG_W    = VIOL_BIT + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic [CFG_W-1:0]  cfg_rdata,
  input logic [ADDR_W-1:0] ext_base,
  input logic [ADDR_W-1:0] ext_limit,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_smm,
  input logic              req_code,
  input logic              req_ewb,
  input logic              route_dram,
  input logic              route_alt
);

  logic win, hit;
  assign win = (req_addr >= WIN_BASE) && ((req_addr - WIN_BASE) < WIN_SIZE);
  assign hit = cfg_rdata[2] && (req_addr >= ext_base) && (req_addr < ext_limit);

  a_r3_outside_dram: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !win |=> route_dram && !route_alt);

  a_r4_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && win && cfg_rdata[1:0] == 2'b00 |=> route_alt);

  a_r4_mode_ram: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && win && cfg_rdata[1:0] == 2'b01 |=> route_dram);

  a_r5_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && win && cfg_rdata[1:0] == 2'b10 |=> (route_dram == $past(req_smm && req_code)));

  a_r6_protected: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && win && cfg_rdata[1:0] == 2'b11 |=> (route_dram == $past(req_smm)));

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({route_dram, route_alt}));

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !route_dram && !route_alt);

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3] |=> cfg_rdata[3]);

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3] |=> $stable(cfg_rdata[VIOL_BIT-1:1]));

  a_r9_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3] && !cfg_rdata[1] |=> $stable(cfg_rdata[0]));

  a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hit && !req_smm && !req_ewb |=> cfg_rdata[VIOL_BIT]);

  a_r11_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[VIOL_BIT]) |-> $past(req_valid && hit && !req_smm && !req_ewb));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[VIOL_BIT] && !(cfg_we && cfg_wdata[VIOL_BIT]) |=> cfg_rdata[VIOL_BIT]);

endmodule

bind smm_window_ctrl smm_window_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .ext_base(ext_base), .ext_limit(ext_limit),
  .req_valid(req_valid), .req_addr(req_addr), .req_smm(req_smm),
  .req_code(req_code), .req_ewb(req_ewb),
  .route_dram(route_dram), .route_alt(route_alt)
);

// File: tb/tb_smm_window_ctrl.sv
module tb_smm_window_ctrl;
  localparam int AW = 32;
  localparam logic [AW-1:0] WB = 32'h000A_0000;
  localparam logic [AW-1:0] WS = 32'h0002_0000;
  localparam logic [AW-1:0] XB = 32'h0010_0000;
  localparam logic [AW-1:0] XL = 32'h0018_0000;

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [6:0] cfg_wdata = '0, cfg_rdata;
  logic [AW-1:0] ext_base = XB, ext_limit = XL, req_addr = '0;
  logic req_valid = 0, req_smm = 0, req_code = 0, req_ewb = 0;
  logic route_dram, route_alt;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  smm_window_ctrl dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(logic [6:0] d);
    @(negedge clk); cfg_we = 1; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rq(logic [AW-1:0] a, logic s, logic c, logic e);
    @(negedge clk); req_valid = 1; req_addr = a; req_smm = s; req_code = c; req_ewb = e;
    @(negedge clk); req_valid = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] addrs [4];
    do_reset();
    chk("R1 reset rdata", cfg_rdata, 0);
    chk("R1 reset strobes", {route_dram, route_alt}, 0);

    // R2 unlocked writes
    for (int w = 0; w < 128; w++) begin
      if (w[3]) continue;
      wr(7'(w));
      chk("R2 unlocked write", cfg_rdata, w & 7'h37);
    end

    // R3..R7 routing sweep
    addrs[0] = WB - 1; addrs[1] = WB; addrs[2] = WB + WS - 1; addrs[3] = WB + WS;
    do_reset();
    for (int m = 0; m < 4; m++) begin
      wr(7'(m));
      for (int ai = 0; ai < 4; ai++)
        for (int k = 0; k < 8; k++) begin
          logic s, c, inw, d;
          s = k[0]; c = k[1];
          inw = (ai == 1) || (ai == 2);
          d = !inw || (m == 1) || (m == 2 && s && c) || (m == 3 && s);
          rq(addrs[ai], s, c, k[2]);
          if (!inw) chk("R3 outside window", {route_dram, route_alt}, 2'b10);
          else if (m < 2) chk("R4 mode 00/01", {route_dram, route_alt}, {d, !d});
          else if (m == 2) chk("R5 code shadow", {route_dram, route_alt}, {d, !d});
          else chk("R6 protected", {route_dram, route_alt}, {d, !d});
        end
      @(negedge clk);
      chk("R7 strobe one cycle", {route_dram, route_alt}, 0);
    end

    // R8/R9 exhaustive locked writes
    for (int s0 = 0; s0 < 64; s0++) begin
      logic [6:0] cur;
      do_reset();
      cur = 7'(s0) | 7'h08;
      wr(cur);
      chk("R8 lock set by write", cfg_rdata, cur);
      for (int w = 0; w < 128; w++) begin
        wr(7'(w));
        if (cur[1]) cur[0] = w[0];
        if (cur[1]) chk("R9 low mode bit writable", cfg_rdata, cur);
        else chk("R8 locked fields frozen", cfg_rdata, cur);
      end
    end
    do_reset();
    chk("R8 reset clears lock", cfg_rdata, 0);

    // R10/R11 violation flag
    addrs[0] = XB - 1; addrs[1] = XB; addrs[2] = XL - 1; addrs[3] = XL;
    for (int ai = 0; ai < 4; ai++)
      for (int k = 0; k < 4; k++) begin
        logic hit;
        wr(7'h44);
        hit = (ai == 1 || ai == 2) && !k[0] && !k[1];
        rq(addrs[ai], k[0], 1'b0, k[1]);
        if (k[1]) chk("R11 writeback never flags", cfg_rdata[6], 0);
        else chk("R10 violation set", cfg_rdata[6], hit);
      end
    wr(7'h40);
    rq(XB, 0, 0, 0);
    chk("R11 range disabled", cfg_rdata[6], 0);
    wr(7'h04);
    rq(XB, 0, 0, 0);
    chk("R10 set", cfg_rdata[6], 1);
    wr(7'h04);
    chk("R10 write 0 keeps flag", cfg_rdata[6], 1);
    rq(32'h0, 0, 0, 0);
    chk("R10 flag sticky", cfg_rdata[6], 1);
    wr(7'h44);
    chk("R10 write 1 clears", cfg_rdata[6], 0);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = 7'h44;
    req_valid = 1; req_addr = XB; req_smm = 0; req_ewb = 0;
    @(negedge clk); cfg_we = 0; req_valid = 0;
    chk("R12 set beats clear", cfg_rdata[6], 1);
    wr(7'h0C);
    rq(XB + 4, 0, 0, 0);
    wr(7'h40);
    chk("R10 W1C works while locked", cfg_rdata[6], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule